// File: doc/BRIEF.md
# Label-Broadcast Event Timing Controller

This block is the fixed-latency back end of a timed event issuer. Upstream logic fills a timing queue with timeline points, each an interval and a label. It also fills one event queue per output channel, each entry a label and an operation code. The controller walks the timeline from these queues. It counts down each interval in clock cycles. When the count runs out it broadcasts the label of that point. In the same cycle, every channel whose head event carries that label releases the event on its output and pops it.

The moment at which an event fires depends only on the buffered intervals and labels. It does not depend on how fast or how unevenly the queues were filled, provided each entry is present by the time it is due. A timeline is launched either by a start command or by an external trigger. It ends in one of two ways. It returns to rest cleanly when the timing queue runs dry and no events are left waiting. If events are still waiting, it stops with a sticky underflow flag.

The controller is a four-state machine. IDLE waits for a launch. RUN counts an interval and broadcasts. FINAL is a one-cycle look at the event queues after the last point. HALT is the stopped state after an underflow. The transitions are as follows:
- Launch: IDLE or HALT to RUN when a launch finds a timing entry.
- Empty launch: IDLE or HALT to HALT when a launch finds the timing queue empty.
- Chain: RUN to RUN when a point is broadcast and a further entry is waiting.
- Drain: RUN to FINAL when a point is broadcast and the timing queue is empty.
- Finish: FINAL to IDLE when all event queues are empty.
- Starve: FINAL to HALT when some event queue is not empty.

Top module: `evt_timeline_ctrl`

## Requirements
- R1: When start_cmd or ext_trig is high at a clock edge while busy is low and the timing queue is not empty, the head timing entry is popped at that edge and busy goes high. The entry's interval is tq_data[INTV_W+LABEL_W-1:LABEL_W] and its label is tq_data[LABEL_W-1:0].
- R2: If the launch is sampled at edge k, the first point is broadcast during the cycle that follows edge k+N-1, where N is its interval. An interval of 0 counts as 1. During that cycle bcast_valid is high and bcast_label equals the point's label.
- R3: The next timing entry is popped in the same cycle as a broadcast. Point j is therefore broadcast after edge k-1 plus the sum of the clamped intervals of points 1..j, with no idle cycle between points.
- R4: During a broadcast, every channel c whose queue is not empty and whose head label equals bcast_label raises ev_valid[c], presents the head operation on ev_op, and pops the head. Several channels may fire in the same cycle. An event entry is {label, op}, with the label in the upper LABEL_W bits and the op in the lower OP_W bits of that channel's slice.
- R5: A channel whose head label differs from the broadcast label does not fire, and its head is kept until a later broadcast carries its label.
- R6: A launch that finds the timing queue empty sets underflow. Underflow is also set one cycle after the last point has been broadcast if any event queue still holds an entry. Underflow stays set until the next launch that finds a timing entry, and while it is set busy is low and no broadcast occurs.
- R7: If every event queue is empty one cycle after the last point, the controller returns to rest with busy low and underflow low.
- R8: start_cmd and ext_trig have no effect while busy is high. The broadcast times and labels of the running timeline are unchanged.
- R9: After reset, busy, underflow, bcast_valid, tq_pop and all of ev_valid and eq_pop are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cmd | input | 1 | Launch request from the command side |
| ext_trig | input | 1 | Launch request from an external trigger |
| tq_empty | input | 1 | Timing queue has no entry |
| tq_data | input | INTV_W+LABEL_W | Head timing entry {interval, label} |
| tq_pop | output | 1 | Consume the head timing entry |
| eq_empty | input | NUM_CH | Per-channel event queue empty |
| eq_data | input | NUM_CH*(LABEL_W+OP_W) | Per-channel head event {label, op} |
| eq_pop | output | NUM_CH | Per-channel consume head event |
| ev_valid | output | NUM_CH | Per-channel event released this cycle |
| ev_op | output | NUM_CH*OP_W | Per-channel released operation code |
| bcast_valid | output | 1 | A timing point is reached this cycle |
| bcast_label | output | LABEL_W | Label of the reached timing point |
| busy | output | 1 | A timeline is running |
| underflow | output | 1 | Sticky timing-queue underflow flag |

## Verification
The assertions assume the queues behave as first-word-fall-through read ports. The empty flags must be true, the head data must stay stable until popped, and each pop must advance by exactly one entry. The bench models its queues with indexed arrays that meet these rules by construction. It loads all entries of a run while the controller is at rest, so no head changes under the controller. Launch and trigger pulses are driven away from the clock edge. Leftover entries after an underflow are discarded only while the controller is at rest.

// File: rtl/tl_pkg.sv
package tl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FINAL = 2'd2,
        ST_HALT  = 2'd3
    } tl_state_e;
endpackage

// File: rtl/tl_interval_counter.sv
module tl_interval_counter #(
    parameter int INTV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INTV_W-1:0] load_val,
    input  logic              run,
    output logic              expire
);
    localparam logic [INTV_W-1:0] ONE = INTV_W'(1);

    logic [INTV_W-1:0] remain_q;

    // interval 0 is clamped to a single cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= (load_val == '0) ? ONE : load_val;
        end else if (run && remain_q > ONE) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign expire = run && (remain_q == ONE);
endmodule

// File: rtl/tl_event_matcher.sv
module tl_event_matcher #(
    parameter int LABEL_W = 4,
    parameter int OP_W    = 4
) (
    input  logic                    bcast_valid,
    input  logic [LABEL_W-1:0]      bcast_label,
    input  logic                    q_empty,
    input  logic [LABEL_W+OP_W-1:0] q_head,
    output logic                    fire,
    output logic                    q_pop,
    output logic [OP_W-1:0]         op
);
    logic [LABEL_W-1:0] head_label;

    assign head_label = q_head[LABEL_W+OP_W-1:OP_W];
    assign fire       = bcast_valid && !q_empty && (head_label == bcast_label);
    assign q_pop      = fire;
    assign op         = fire ? q_head[OP_W-1:0] : '0;
endmodule

// File: rtl/evt_timeline_ctrl.sv
module evt_timeline_ctrl
    import tl_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int LABEL_W = 4,
    parameter int INTV_W  = 8,
    parameter int OP_W    = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_cmd,
    input  logic                             ext_trig,
    input  logic                             tq_empty,
    input  logic [INTV_W+LABEL_W-1:0]        tq_data,
    output logic                             tq_pop,
    input  logic [NUM_CH-1:0]                eq_empty,
    input  logic [NUM_CH*(LABEL_W+OP_W)-1:0] eq_data,
    output logic [NUM_CH-1:0]                eq_pop,
    output logic [NUM_CH-1:0]                ev_valid,
    output logic [NUM_CH*OP_W-1:0]           ev_op,
    output logic                             bcast_valid,
    output logic [LABEL_W-1:0]               bcast_label,
    output logic                             busy,
    output logic                             underflow
);
    localparam int EV_W = LABEL_W + OP_W;

    tl_state_e          state_q, state_d;
    logic               launch_req;
    logic               expire;
    logic               cnt_load;
    logic               uf_set, uf_clr;
    logic [LABEL_W-1:0] label_q;
    logic [INTV_W-1:0]  head_intv;
    logic [LABEL_W-1:0] head_label;

    assign launch_req = start_cmd || ext_trig;
    assign head_intv  = tq_data[INTV_W+LABEL_W-1:LABEL_W];
    assign head_label = tq_data[LABEL_W-1:0];

    tl_interval_counter #(.INTV_W(INTV_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (head_intv),
        .run      (state_q == ST_RUN),
        .expire   (expire)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // label of the point being counted, and the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            label_q   <= '0;
            underflow <= 1'b0;
        end else begin
            if (cnt_load) begin
                label_q <= head_label;
            end
            if (uf_set) begin
                underflow <= 1'b1;
            end else if (uf_clr) begin
                underflow <= 1'b0;
            end
        end
    end

    // next state and control outputs
    always_comb begin
        state_d  = state_q;
        tq_pop   = 1'b0;
        cnt_load = 1'b0;
        uf_set   = 1'b0;
        uf_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_HALT: begin
                if (launch_req) begin
                    if (!tq_empty) begin
                        tq_pop   = 1'b1;
                        cnt_load = 1'b1;
                        uf_clr   = 1'b1;
                        state_d  = ST_RUN;
                    end else begin
                        uf_set  = 1'b1;
                        state_d = ST_HALT;
                    end
                end
            end
            ST_RUN: begin
                if (expire) begin
                    if (!tq_empty) begin
                        tq_pop   = 1'b1;
                        cnt_load = 1'b1;
                    end else begin
                        state_d = ST_FINAL;
                    end
                end
            end
            ST_FINAL: begin
                if (&eq_empty) begin
                    state_d = ST_IDLE;
                end else begin
                    uf_set  = 1'b1;
                    state_d = ST_HALT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign bcast_valid = expire;
    assign bcast_label = label_q;
    assign busy        = (state_q == ST_RUN) || (state_q == ST_FINAL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tl_event_matcher #(.LABEL_W(LABEL_W), .OP_W(OP_W)) u_match (
            .bcast_valid (bcast_valid),
            .bcast_label (label_q),
            .q_empty     (eq_empty[c]),
            .q_head      (eq_data[c*EV_W +: EV_W]),
            .fire        (ev_valid[c]),
            .q_pop       (eq_pop[c]),
            .op          (ev_op[c*OP_W +: OP_W])
        );
    end
endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_cmd,
    input logic              ext_trig,
    input logic              tq_empty,
    input logic              tq_pop,
    input logic [NUM_CH-1:0] eq_empty,
    input logic [NUM_CH-1:0] ev_valid,
    input logic              bcast_valid,
    input logic              busy,
    input logic              underflow
);
    assert_pop_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tq_pop |-> !tq_empty);

    assert_bcast_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> busy && !underflow);

    assert_busy_pop_only_on_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tq_pop) |-> bcast_valid);

    assert_launch_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (start_cmd || ext_trig) && !bcast_valid) |-> !tq_pop);

    assert_uf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !start_cmd && !ext_trig) |=> underflow);

    assert_uf_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> !busy);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bcast_valid && ev_valid == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_fire_on_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ev_valid[c] |-> (bcast_valid && !eq_empty[c]));
    end
endmodule

bind evt_timeline_ctrl tl_checker #(.NUM_CH(NUM_CH)) u_tl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cmd   (start_cmd),
    .ext_trig    (ext_trig),
    .tq_empty    (tq_empty),
    .tq_pop      (tq_pop),
    .eq_empty    (eq_empty),
    .ev_valid    (ev_valid),
    .bcast_valid (bcast_valid),
    .busy        (busy),
    .underflow   (underflow)
);

// File: tb/evt_timeline_ctrl_bench.sv
module evt_timeline_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int LW  = 4;
    localparam int IW  = 8;
    localparam int OW  = 4;
    localparam int EW  = LW + OW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_cmd = 1'b0;
    logic ext_trig = 1'b0;
    logic tq_empty, tq_pop;
    logic [IW+LW-1:0] tq_data;
    logic [NCH-1:0] eq_empty, eq_pop, ev_valid;
    logic [NCH*EW-1:0] eq_data;
    logic [NCH*OW-1:0] ev_op;
    logic bcast_valid, busy, underflow;
    logic [LW-1:0] bcast_label;

    // queue models: read pointers advance on pops, skip offsets discard leftovers
    logic [IW+LW-1:0] tq_mem [256];
    logic [EW-1:0]    eq_mem [NCH][256];
    logic [7:0] tq_rd, tq_wr = 8'd0, tq_skip = 8'd0, tq_head;
    logic [7:0] eq_rd [NCH];
    logic [7:0] eq_wr [NCH] = '{default: 8'd0};
    logic [7:0] eq_skip [NCH] = '{default: 8'd0};
    logic [7:0] eq_head [NCH];

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    int blog_t [512];
    int blog_l [512];
    int blog_n = 0;
    int elog_t [NCH][256];
    int elog_o [NCH][256];
    int elog_n [NCH] = '{default: 0};

    int s_n;
    int s_iv [8];
    int s_lb [8];
    int e_n  [NCH];
    int e_lb [NCH][8];
    int e_op [NCH][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tq_head  = tq_rd + tq_skip;
    assign tq_empty = (tq_head == tq_wr);
    assign tq_data  = tq_mem[tq_head];
    for (genvar c = 0; c < NCH; c++) begin : g_q
        assign eq_head[c]          = eq_rd[c] + eq_skip[c];
        assign eq_empty[c]         = (eq_head[c] == eq_wr[c]);
        assign eq_data[c*EW +: EW] = eq_mem[c][eq_head[c]];
    end

    evt_timeline_ctrl #(.NUM_CH(NCH), .LABEL_W(LW), .INTV_W(IW), .OP_W(OW)) u_evt_timeline_ctrl (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .ext_trig(ext_trig),
        .tq_empty(tq_empty), .tq_data(tq_data), .tq_pop(tq_pop),
        .eq_empty(eq_empty), .eq_data(eq_data), .eq_pop(eq_pop),
        .ev_valid(ev_valid), .ev_op(ev_op), .bcast_valid(bcast_valid),
        .bcast_label(bcast_label), .busy(busy), .underflow(underflow)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            tq_rd <= 8'd0;
            for (int c = 0; c < NCH; c++) eq_rd[c] <= 8'd0;
        end else begin
            if (tq_pop) tq_rd <= tq_rd + 8'd1;
            for (int c = 0; c < NCH; c++) if (eq_pop[c]) eq_rd[c] <= eq_rd[c] + 8'd1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (bcast_valid) begin
                blog_t[blog_n] = cyc;
                blog_l[blog_n] = int'(bcast_label);
                blog_n = blog_n + 1;
            end
            for (int c = 0; c < NCH; c++) begin
                if (ev_valid[c]) begin
                    elog_t[c][elog_n[c]] = cyc;
                    elog_o[c][elog_n[c]] = int'(ev_op[c*OW +: OW]);
                    elog_n[c] = elog_n[c] + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic flush_queues();
        @(negedge clk);
        tq_skip = tq_wr - tq_rd;
        for (int c = 0; c < NCH; c++) eq_skip[c] = eq_wr[c] - eq_rd[c];
    endtask

    // load the schedule, launch, wait, and compare against the arithmetic model
    task automatic run_scn(input bit use_trig, input int poke_at);
        int ks, t, total, b0;
        int e0 [NCH];
        int hd [NCH];
        bit left;
        @(negedge clk);
        for (int j = 0; j < s_n; j++) begin
            tq_mem[tq_wr] = {s_iv[j][IW-1:0], s_lb[j][LW-1:0]};
            tq_wr = tq_wr + 8'd1;
        end
        for (int c = 0; c < NCH; c++) begin
            for (int j = 0; j < e_n[c]; j++) begin
                eq_mem[c][eq_wr[c]] = {e_lb[c][j][LW-1:0], e_op[c][j][OW-1:0]};
                eq_wr[c] = eq_wr[c] + 8'd1;
            end
            e0[c] = elog_n[c];
            hd[c] = 0;
        end
        b0 = blog_n;
        total = 0;
        for (int j = 0; j < s_n; j++) total += (s_iv[j] == 0) ? 1 : s_iv[j];
        if (use_trig) ext_trig = 1'b1; else start_cmd = 1'b1;
        ks = cyc + 1;
        @(negedge clk);
        ext_trig = 1'b0;
        start_cmd = 1'b0;
        check(busy == 1'b1, "R1", "busy after launch", int'(busy), 1);
        for (int i = 0; i < total + 6; i++) begin
            @(negedge clk);
            start_cmd = (i == poke_at);
            ext_trig  = (i == poke_at);
        end
        start_cmd = 1'b0;
        ext_trig  = 1'b0;
        check(blog_n - b0 == s_n, "R3", "broadcast count", blog_n - b0, s_n);
        t = ks - 1;
        for (int j = 0; j < s_n; j++) begin
            t += (s_iv[j] == 0) ? 1 : s_iv[j];
            if (j < blog_n - b0) begin
                check(blog_t[b0+j] == t, "R2", "broadcast cycle", blog_t[b0+j], t);
                check(blog_l[b0+j] == s_lb[j], "R2", "broadcast label", blog_l[b0+j], s_lb[j]);
            end
            for (int c = 0; c < NCH; c++) begin
                if (hd[c] < e_n[c] && e_lb[c][hd[c]] == s_lb[j]) begin
                    if (hd[c] < elog_n[c] - e0[c]) begin
                        check(elog_t[c][e0[c]+hd[c]] == t, "R4", "event cycle",
                              elog_t[c][e0[c]+hd[c]], t);
                        check(elog_o[c][e0[c]+hd[c]] == e_op[c][hd[c]], "R4", "event op",
                              elog_o[c][e0[c]+hd[c]], e_op[c][hd[c]]);
                    end
                    hd[c]++;
                end
            end
        end
        left = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            check(elog_n[c] - e0[c] == hd[c], "R5", "events fired on channel",
                  elog_n[c] - e0[c], hd[c]);
            if (hd[c] < e_n[c]) left = 1'b1;
        end
        check(busy == 1'b0, "R7", "busy at end", int'(busy), 0);
        check(underflow == left, left ? "R6" : "R7", "underflow at end",
              int'(underflow), int'(left));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy == 0, "R9", "busy in reset", int'(busy), 0);
        check(underflow == 0, "R9", "underflow in reset", int'(underflow), 0);
        check(bcast_valid == 0 && tq_pop == 0, "R9", "broadcast/pop in reset",
              int'(bcast_valid | tq_pop), 0);
        check(ev_valid == 0 && eq_pop == 0, "R9", "events in reset", int'(ev_valid | eq_pop), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of interval pairs; label 3 repeats so both channels fire together
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                s_n = 3;
                s_iv[0] = a; s_lb[0] = 3;
                s_iv[1] = b; s_lb[1] = 7;
                s_iv[2] = 2; s_lb[2] = 3;
                e_n[0] = 2; e_lb[0][0] = 3; e_op[0][0] = a + 1; e_lb[0][1] = 3; e_op[0][1] = b + 6;
                e_n[1] = 2; e_lb[1][0] = 7; e_op[1][0] = 9;     e_lb[1][1] = 3; e_op[1][1] = 12;
                run_scn((a + b) % 2 == 1, -1);
            end
        end

        // R8: launch pulses while running change nothing
        s_n = 2;
        s_iv[0] = 6; s_lb[0] = 4;
        s_iv[1] = 6; s_lb[1] = 5;
        e_n[0] = 1; e_lb[0][0] = 4; e_op[0][0] = 2;
        e_n[1] = 1; e_lb[1][0] = 5; e_op[1][0] = 11;
        run_scn(1'b0, 2);
        run_scn(1'b1, 7);

        // R6: events left behind after the last point
        s_n = 1;
        s_iv[0] = 3; s_lb[0] = 1;
        e_n[0] = 2; e_lb[0][0] = 1; e_op[0][0] = 4; e_lb[0][1] = 5; e_op[0][1] = 6;
        e_n[1] = 0;
        run_scn(1'b0, -1);
        repeat (3) @(negedge clk);
        check(underflow == 1, "R6", "underflow held", int'(underflow), 1);
        flush_queues();

        // R6: a launch with a timing entry clears the flag (expected 0 at end)
        s_n = 1;
        s_iv[0] = 2; s_lb[0] = 2;
        e_n[0] = 1; e_lb[0][0] = 2; e_op[0][0] = 8;
        e_n[1] = 0;
        run_scn(1'b1, -1);

        // R6: launch into an empty timing queue
        begin
            int b0;
            b0 = blog_n;
            @(negedge clk);
            start_cmd = 1'b1;
            @(negedge clk);
            start_cmd = 1'b0;
            repeat (4) @(negedge clk);
            check(underflow == 1, "R6", "underflow on empty launch", int'(underflow), 1);
            check(busy == 0, "R6", "busy on empty launch", int'(busy), 0);
            check(blog_n == b0, "R6", "broadcasts on empty launch", blog_n - b0, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule